// File: doc/BRIEF.md
# Programmable Clock Divider with Chained Down-Counting Digits

This block turns a free-running input clock into a stream of one-cycle pulses whose rate is the input rate divided by an 8-bit ratio N. The ratio is applied in binary on a parallel input. Two 4-bit down-counting digits are chained through an active-low carry. The low digit steps on every clock. The high digit steps only in the one cycle when the low digit's carry is active.

When both digits reach zero, the next clock edge reloads the counter from the ratio input and raises the output pulse for one cycle. Because the reload is synchronous, the pulse is never fed back into the counter, and a ratio changed mid-period only takes effect at the next reload. A ratio of zero is illegal: the output stays low and a flag reports the condition for as long as the ratio is zero.

Top module: `fdiv_divider`

## Requirements
- R1: For any ratio N from 1 to 255, `divOut` is high in exactly one cycle out of every N input clocks. With N = 1 it is high in every cycle.
- R2: While `rst` is high, `divOut` is low and the counter is loaded from `ratio`. The first pulse is visible after the Nth rising edge at which `rst` is low.
- R3: For N of 2 or more, each pulse lasts exactly one cycle, and a pulse only follows a cycle in which the counter stood at terminal count.
- R4: The low digit decrements on every clock. Its active-low carry stays low for a single cycle when the digit is zero, and only then does the high digit decrement. Ratios of 15, 16 and 17 therefore still give periods of exactly 15, 16 and 17.
- R5: When `ratio` is zero, `ratioBad` is high in the same cycle and `divOut` is low after every edge at which the ratio was zero.
- R6: A new ratio applied during a period does not shorten or lengthen that period. The next period uses the new ratio.
- R7: The largest ratio, 255 (all ones), gives a period of 255 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; loads the counter and clears the output |
| ratio | input | 8 | Division ratio N, unsigned binary |
| divOut | output | 1 | Divided output, one-cycle pulse per N clocks |
| ratioBad | output | 1 | High while `ratio` is zero |

## Verification
The bench builds the block with its default shape: two 4-bit digits, for an 8-bit ratio. With that shape, every carry handoff between the digits, the all-ones ratio and the zero ratio can be reached within a few thousand cycles. Ratios just below, at and just above a digit boundary (15, 16, 17) exercise the single-cycle carry. Ratios of 1 and 255 cover the two ends of the legal range. A ratio swap right after a pulse shows that the switch happens at the reload boundary.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // Strobes from the control half to the counting datapath.
  typedef struct packed {
    logic load;  // reload the digits from the ratio
    logic fire;  // emit an output pulse on this edge
  } fdivStrobe_t;
endpackage

// File: rtl/fdiv_datapath.sv
module fdiv_datapath
  import fdiv_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int DIGITS  = 2,
  localparam int RATIO_W = DIGIT_W * DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  fdivStrobe_t        strobe,
  input  logic [RATIO_W-1:0] ratio,
  output logic               terminalN
);
  logic [RATIO_W-1:0] loadVal;
  logic [DIGITS:0]    chainN;

  // Period N needs N states: N-1 down to 0. A zero ratio parks the digits at zero.
  assign loadVal   = (ratio == '0) ? '0 : ratio - 1'b1;
  assign chainN[0] = 1'b0;  // the lowest digit is always enabled

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [DIGIT_W-1:0] digit;

    always_ff @(posedge clk) begin
      if (strobe.load) digit <= loadVal[g*DIGIT_W +: DIGIT_W];
      else if (!chainN[g]) digit <= digit - 1'b1;
    end

    // Active-low carry: low when this digit is enabled and sits at zero.
    assign chainN[g+1] = !(!chainN[g] && (digit == '0));

    if (g == 0) begin : gLowChk
      AST_CARRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!chainN[1] && !strobe.load) |=> chainN[1]); // R4
    end else begin : gHighChk
      AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (chainN[g] && !strobe.load) |=> $stable(digit)); // R4
    end
  end

  assign terminalN = chainN[DIGITS];
endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               terminalN,
  output fdivStrobe_t        strobe,
  output logic               divOut,
  output logic               ratioBad
);
  assign ratioBad = (ratio == '0);

  always_comb begin
    strobe.load = rst || !terminalN;
    strobe.fire = !rst && !terminalN && !ratioBad;
  end

  always_ff @(posedge clk) begin
    divOut <= strobe.fire;
  end

  AST_QUIET_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    ratioBad |=> !divOut); // R5
  AST_PULSE_FROM_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    divOut |-> $past(!terminalN)); // R3
endmodule

// File: rtl/fdiv_divider.sv
module fdiv_divider
  import fdiv_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int DIGITS  = 2,
  localparam int RATIO_W = DIGIT_W * DIGITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  output logic               divOut,
  output logic               ratioBad
);
  fdivStrobe_t strobe;
  logic        terminalN;

  fdiv_datapath #(.DIGIT_W(DIGIT_W), .DIGITS(DIGITS)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .ratio(ratio), .terminalN(terminalN)
  );

  fdiv_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rst(rst), .ratio(ratio), .terminalN(terminalN),
    .strobe(strobe), .divOut(divOut), .ratioBad(ratioBad)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !divOut); // R2
endmodule

// File: tb/fdiv_divider_bench.sv
module fdiv_divider_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ratio = 8'd3;
  logic       divOut, ratioBad;

  int    nChecks = 0, nErrors = 0, cycles = 0;
  string reqTag = "R2";
  int    mCnt = 0;
  logic  mExp = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fdiv_divider u_fdiv_divider (
    .clk(clk), .rst(rst), .ratio(ratio), .divOut(divOut), .ratioBad(ratioBad)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, got, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // Behavioural reference: integer count of clocks left in the period.
  always @(posedge clk) begin
    if (rst) begin
      mCnt = (ratio == 0) ? 0 : ratio - 1;
      mExp = 1'b0;
    end else if (mCnt == 0) begin
      mExp = (ratio != 0);
      mCnt = (ratio == 0) ? 0 : ratio - 1;
    end else begin
      mCnt = mCnt - 1;
      mExp = 1'b0;
    end
  end

  // Compare every cycle, one nanosecond after the edge.
  always begin
    @(posedge clk);
    #1;
    cycles++;
    check(divOut === mExp, reqTag, "divOut vs model", int'(divOut), int'(mExp));
    check(ratioBad === (ratio == 0), "R5", "ratioBad", int'(ratioBad), int'(ratio == 0));
    if (cycles > 100000) begin
      check(1'b0, "watchdog", "run hung", cycles, 100000);
      finishRun();
    end
  end

  task automatic nextPulse(output int gap);
    gap = 0;
    do begin
      @(posedge clk);
      #1;
      gap++;
    end while (divOut !== 1'b1 && gap < 600);
  endtask

  task automatic measureRatio(input int n, input string req);
    int gap;
    ratio = n[7:0];
    reqTag = req;
    nextPulse(gap);  // finishes the period running on the old ratio
    nextPulse(gap);
    check(gap == n, req, $sformatf("period for N=%0d", n), gap, n);
    if (n > 1) begin
      @(posedge clk);
      #1;
      check(divOut == 1'b0, req, "pulse width one cycle (R3)", int'(divOut), 0);
    end
  endtask

  initial begin
    int gap;
    repeat (3) @(posedge clk);
    #1;
    check(divOut == 1'b0, "R2", "divOut during reset", int'(divOut), 0);
    @(negedge clk);
    rst = 1'b0;
    nextPulse(gap);
    check(gap == 3, "R2", "first pulse after reset", gap, 3);

    measureRatio(3, "R1");
    measureRatio(7, "R1");
    measureRatio(1, "R1");
    measureRatio(2, "R3");
    measureRatio(15, "R4");
    measureRatio(16, "R4");
    measureRatio(17, "R4");
    measureRatio(32, "R4");
    measureRatio(255, "R7");

    // R5: zero ratio keeps the output quiet and raises the flag.
    ratio = 8'd0;
    reqTag = "R5";
    repeat (300) begin
      @(posedge clk);
      #1;
    end
    check(divOut == 1'b0, "R5", "divOut with zero ratio", int'(divOut), 0);
    check(ratioBad == 1'b1, "R5", "flag with zero ratio", int'(ratioBad), 1);

    // R6: change the ratio right after a pulse; the current period keeps the old value.
    ratio = 8'd10;
    reqTag = "R6";
    nextPulse(gap);
    nextPulse(gap);
    ratio = 8'd4;
    nextPulse(gap);
    check(gap == 10, "R6", "period before switch", gap, 10);
    nextPulse(gap);
    check(gap == 4, "R6", "period after switch", gap, 4);

    // R2: a mid-period reset restarts the count from the ratio.
    @(negedge clk);
    rst = 1'b1;
    reqTag = "R2";
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nextPulse(gap);
    check(gap == 4, "R2", "first pulse after second reset", gap, 4);

    repeat (4) @(posedge clk);
    #2;
    finishRun();
  end
endmodule